// File: doc/BRIEF.md
# Radix-4 Recoded Unsigned Multiplier

This block multiplies two unsigned N-bit operands and presents the 2N-bit product from a register one clock after the operands are applied. The multiplier operand is rewritten as a string of signed base-four digits, each drawn from {-2, -1, 0, +1, +2}. That halves the number of partial products and removes any need to form three times the multiplicand.

Every digit is reduced to three control bits: negate, double and clear. A partial product is then formed from X with plain gating: a one-bit left shift, a bitwise inversion, or forcing to zero. Each row is sign-extended to the product width and offset by two bit positions per digit. The rows are summed by a carry-save tree that feeds one final carry-propagate adder. An inverted row lacks the +1 of two's complement. That bit goes into a low-order position of the next row which is known to be zero, so no extra adder stage is needed.

Top module: `booth_mul`

## Requirements
- R1: While rst_n is low, and on the first clock edge that samples rst_n low, prod_o becomes zero whatever x_i and y_i hold.
- R2: Out of reset, the value of prod_o after a rising edge equals x_i * y_i as sampled at that edge, so there is one cycle of latency.
- R3: The multiplier is recoded from overlapping three-bit windows {y[2k+1], y[2k], y[2k-1]}, with y[-1] = 0. The windows map as follows: 000 and 111 to zero, 001 and 010 to +1, 011 to +2, 100 to -2, 101 and 110 to -1. No digit both doubles and clears.
- R4: y_i is zero-extended by two bits, giving N/2+1 digits. The most significant digit is never negative, so y_i with its top bit set multiplies correctly.
- R5: When y_i is all ones, a window of 111 occurs and produces a negated zero row. Its injected +1 cancels the inverted row exactly, and the product is still exact.
- R6: A zero value on either operand gives a zero product.
- R7: 94 * 121 gives 11374.
- R8: The product never exceeds (2^N-1)^2. With both operands all ones, the product is exactly (2^N-1)^2.
- R9: For N = 8 the product is exact for every one of the 65536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x_i | input | N | Multiplicand, unsigned |
| y_i | input | N | Multiplier, unsigned, recoded into digits |
| prod_o | output | 2N | Registered unsigned product |

## Verification
A negative digit inverts its row, and the +1 that completes the negation lands in the row above. One product can therefore depend on both the inversion and the injection in the same cycle. The hardest case is a window of 111, where an inverted zero row must be cancelled exactly by the bit injected into the next row. The bench provokes this with all-ones and alternating multiplier patterns next to ordinary ones. Each result is judged against an independent integer multiply held in a scoreboard queue.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Controls for one radix-4 digit
    typedef struct packed {
        logic neg;   // invert the selected multiple
        logic dbl;   // select 2X instead of X
        logic zro;   // clear the selected multiple
    } digit_ctl_t;

    // Map one overlapping window {y[2k+1], y[2k], y[2k-1]} to controls
    function automatic digit_ctl_t recode_window(input logic [2:0] win);
        digit_ctl_t c;
        c.neg = win[2];
        c.dbl = (win == 3'b011) || (win == 3'b100);
        c.zro = (win == 3'b000) || (win == 3'b111);
        return c;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]                y_i,
    output digit_ctl_t [N/2:0]          ctl_o
);
    localparam int ND = N/2 + 1;
    localparam int YW = N + 3;

    logic [YW-1:0] y_ext;

    // two zero bits on top (unsigned), implicit y[-1] = 0 at the bottom
    assign y_ext = {2'b00, y_i, 1'b0};

    for (genvar k = 0; k < ND; k++) begin : g_dig
        assign ctl_o[k] = recode_window(y_ext[2*k+2 : 2*k]);
    end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]                x_i,
    input  digit_ctl_t [N/2:0]          ctl_i,
    output logic [N/2:0][2*N-1:0]       rows_o
);
    localparam int ND = N/2 + 1;
    localparam int PW = 2*N;
    localparam int MW = N + 1;   // magnitude of 0, X or 2X
    localparam int SW = N + 2;   // with sign bit
    localparam int XW = PW - SW; // sign extension width

    for (genvar k = 0; k < ND; k++) begin : g_row
        logic [MW-1:0] mag;
        logic [SW-1:0] pp;
        logic [PW-1:0] ext;
        logic [PW-1:0] placed;

        always_comb begin
            if (ctl_i[k].zro)
                mag = '0;
            else if (ctl_i[k].dbl)
                mag = {x_i, 1'b0};
            else
                mag = {1'b0, x_i};
            // ones' complement only: the +1 is injected one row up
            pp     = ctl_i[k].neg ? ~{1'b0, mag} : {1'b0, mag};
            ext    = {{XW{pp[SW-1]}}, pp};
            placed = ext << (2*k);
        end

        if (k == 0) begin : g_first
            assign rows_o[k] = placed;
        end else begin : g_hole
            // bit 2(k-1) of this row is always zero after the shift
            assign rows_o[k] = placed | (PW'(ctl_i[k-1].neg) << (2*(k-1)));
        end
    end

endmodule

// File: rtl/booth_csa_sum.sv
module booth_csa_sum #(
    parameter int N = 8
) (
    input  logic [N/2:0][2*N-1:0] rows_i,
    output logic [2*N-1:0]        sum_o
);
    localparam int ND = N/2 + 1;
    localparam int PW = 2*N;

    logic [PW-1:0] s_acc;
    logic [PW-1:0] c_acc;

    // linear chain of 3:2 compressors, redundant form until the end
    always_comb begin
        logic [PW-1:0] s_n;
        logic [PW-1:0] c_n;
        s_acc = rows_i[0];
        c_acc = '0;
        for (int k = 1; k < ND; k++) begin
            s_n   = s_acc ^ c_acc ^ rows_i[k];
            c_n   = ((s_acc & c_acc) | (s_acc & rows_i[k]) | (c_acc & rows_i[k])) << 1;
            s_acc = s_n;
            c_acc = c_n;
        end
    end

    assign sum_o = s_acc + c_acc;

endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    x_i,
    input  logic [N-1:0]    y_i,
    output logic [2*N-1:0]  prod_o
);
    localparam int ND = N/2 + 1;
    localparam int PW = 2*N;

    typedef struct packed {
        logic [PW-1:0] prod;
    } mul_state_t;

    digit_ctl_t [ND-1:0]         dig_ctl;
    logic [ND-1:0][PW-1:0]       pp_rows;
    logic [PW-1:0]               sum_w;
    mul_state_t                  st_d;
    mul_state_t                  st_q;

    booth_recoder #(.N(N)) u_rec (
        .y_i   (y_i),
        .ctl_o (dig_ctl)
    );

    booth_pp_gen #(.N(N)) u_ppg (
        .x_i    (x_i),
        .ctl_i  (dig_ctl),
        .rows_o (pp_rows)
    );

    booth_csa_sum #(.N(N)) u_sum (
        .rows_i (pp_rows),
        .sum_o  (sum_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prod = sum_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign prod_o = st_q.prod;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         x_i,
    input  logic [N-1:0]         y_i,
    input  logic [2*N-1:0]       prod_o,
    input  digit_ctl_t [N/2:0]   ctl
);
    localparam int ND = N/2 + 1;
    localparam int PW = 2*N;
    localparam logic [PW-1:0] MAXP = PW'((2**N - 1) * (2**N - 1));

    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            live_q <= 1'b0;
        else
            live_q <= 1'b1;
    end

    // R2
    a_r2_registered_product: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> prod_o == ({{N{1'b0}}, $past(x_i)} * {{N{1'b0}}, $past(y_i)}));

    // R6
    a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(x_i) == '0 || $past(y_i) == '0)) |-> prod_o == '0);

    // R8
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        prod_o <= MAXP);

    // R4
    a_r4_top_digit_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[ND-1].neg);

    // R3
    for (genvar k = 0; k < ND; k++) begin : g_dchk
        a_r3_no_double_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !(ctl[k].dbl && ctl[k].zro));
    end

endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .x_i    (x_i),
    .y_i    (y_i),
    .prod_o (prod_o),
    .ctl    (dig_ctl)
);

// File: tb/booth_mul_tb_top.sv
module booth_mul_tb_top;
    localparam int N  = 8;
    localparam int PW = 2*N;

    typedef struct {
        logic [PW-1:0] exp;
        logic [N-1:0]  xa;
        logic [N-1:0]  ya;
        string         req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  x_i = '0;
    logic [N-1:0]  y_i = '0;
    logic [PW-1:0] prod_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;   // 4 ns period

    booth_mul #(.N(N)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_i    (x_i),
        .y_i    (y_i),
        .prod_o (prod_o)
    );

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: applies operands and pushes the expected product
    task automatic drive(input logic [N-1:0] xa, input logic [N-1:0] ya, input string req);
        item_t it;
        @(negedge clk);
        x_i = xa;
        y_i = ya;
        it.xa  = xa;
        it.ya  = ya;
        it.exp = PW'(int'(xa) * int'(ya));
        it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: one cycle after each push, compare and pop
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(prod_o === it.exp, it.req, prod_o, it.exp);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset with nonzero operands present
        x_i = 8'hFF;
        y_i = 8'hFF;
        repeat (3) @(negedge clk);
        check(prod_o === '0, "R1", prod_o, '0);
        rst_n = 1'b1;

        drive(8'd94,  8'd121, "R7");
        drive(8'd0,   8'd200, "R6");
        drive(8'd173, 8'd0,   "R6");
        drive(8'd255, 8'd255, "R8");
        drive(8'd77,  8'hFF,  "R5");
        drive(8'd1,   8'hFF,  "R5");
        drive(8'd200, 8'h80,  "R4");
        drive(8'd255, 8'hC0,  "R4");
        drive(8'd91,  8'h55,  "R3");
        drive(8'd91,  8'hAA,  "R3");
        drive(8'd13,  8'h33,  "R3");
        drive(8'd13,  8'hCC,  "R3");
        drive(8'd250, 8'h66,  "R3");
        drive(8'd250, 8'h99,  "R2");
        drive(8'd3,   8'd5,   "R2");

        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(N'(a), N'(b), "R9");
            end
        end

        @(negedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "R2", PW'(sb_q.size()), '0);

        // R1: reset mid-run clears the held product
        x_i = 8'd200;
        y_i = 8'd199;
        @(negedge clk);
        check(prod_o === PW'(200 * 199), "R2", prod_o, PW'(200 * 199));
        rst_n = 1'b0;
        @(negedge clk);
        check(prod_o === '0, "R1", prod_o, '0);

        finish_run();
    end

endmodule